// File: doc/BRIEF.md
# Word-Level Loopback Self-Test Unit

This block checks that a serial command/response bus terminal really hears what it sends. When the final word of a message enters the encoder, the block stores that word's data, its sync type and its memory address. It then waits a bounded time for the decoder to return a word. It compares the two words and records the result. In controller mode the returned word is also written to the memory slot just after the message's last word, so the host can compare the pair. In terminal mode a failure raises the terminal-flag bit of the status word.

A software-requested off-line variant runs only in controller mode. While it runs, the line transmitters stay disabled and the decoder takes the encoder's own words instead of the bus receiver. Line coding is not modelled. Every word crosses as a valid strobe with data, a sync bit and, on the receive side, a parity-error bit. The decoder path adds one register stage.

Top module: `loopback_selftest`

## Requirements
- R1: After reset, `loop_fail`, `term_flag`, `wb_we` and `test_done` are 0 and `tx_en` is 1.
- R2: A returned word that matches the stored last word in data and sync, with no parity error, gives one `test_done` pulse and leaves `loop_fail` at 0.
- R3: A returned word whose 16 data bits differ from the stored word sets `loop_fail`.
- R4: A returned word whose sync bit differs (1 = command/status sync, 0 = data sync) sets `loop_fail`.
- R5: A returned word that arrives with `rx_perr` high sets `loop_fail`.
- R6: Let the last word be sampled at clock edge k. A bus word sampled at edge k+d is accepted for d from 1 to TMO_CYC-1. If no word has come back, `loop_fail` is set at edge k+TMO_CYC, and any later word is ignored.
- R7: In controller mode (`mode_ctl`=1) each returned word causes exactly one `wb_we` pulse, at address last-word address + 1, carrying the returned data, whether it matched or not. No write happens in terminal mode or after a timeout.
- R8: A failure in terminal mode sets `term_flag`, which stays set until reset. A failure in controller mode never sets it.
- R9: `msg_start` clears `loop_fail` on the next edge.
- R10: A `msg_start` with `offline_req`=1 in controller mode drives `tx_en` low until the next `msg_start`. Meanwhile the decoder takes the encoder words, and bus receive words have no effect.
- R11: In terminal mode, `offline_req` is ignored: `tx_en` stays 1 and the bus receiver stays in use.
- R12: Only the word marked `tx_last` is tested. A bad echo returned for an earlier word of the message has no effect on `loop_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ctl | input | 1 | 1 = controller mode, 0 = terminal mode |
| msg_start | input | 1 | One-cycle pulse when a message is launched |
| offline_req | input | 1 | Off-line test request from the control word, sampled with `msg_start` |
| tx_valid | input | 1 | Word handed to the encoder |
| tx_last | input | 1 | The word is the final word of the message |
| tx_sync | input | 1 | Sync type of the word handed to the encoder |
| tx_data | input | 16 | Data of the word handed to the encoder |
| tx_addr | input | 13 | Memory address of the word handed to the encoder |
| rx_valid | input | 1 | Word decoded from the bus receiver |
| rx_sync | input | 1 | Sync type of the received word |
| rx_data | input | 16 | Data of the received word |
| rx_perr | input | 1 | Parity error reported by the decoder |
| tx_en | output | 1 | Line transmitter enable |
| loop_fail | output | 1 | Loop-test-fail bit for the block status word |
| term_flag | output | 1 | Terminal-flag bit for the status word |
| wb_we | output | 1 | Write strobe for the returned word |
| wb_addr | output | 13 | Write-back address |
| wb_data | output | 16 | Write-back data |
| test_done | output | 1 | One-cycle pulse when a test completes |

## Verification
The bench targets the edges of the echo window. An echo one cycle before the timeout must pass, and an echo exactly at the timeout must fail. A counter that is off by one would flip one of the two results. For each failure mode (one flipped data bit, a flipped sync bit, a parity error) the bench checks both the fail bit and the write-back of the bad word, so dropping a term from the comparison or skipping the write on a mismatch shows up. Each message carries a deliberately wrong echo for an earlier word, and the off-line message drives junk on the bus receiver. A design that tested every word, or that kept listening to the bus while off-line, would report a false failure. In terminal mode the bench checks that the flag stays set across a later passing message and is cleared only by reset. It also checks that an off-line request there leaves the transmitters enabled.

// File: rtl/lbst_pkg.sv
package lbst_pkg;
  localparam int DW = 16;
  localparam int AW = 13;

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;
  typedef enum logic {ST_IDLE, ST_WAIT} lbst_st_e;

  // A returned word is bad when data, sync or parity disagree.
  function automatic logic echo_bad(word_t exp_d, logic exp_s,
                                    word_t got_d, logic got_s, logic perr);
    return (exp_d != got_d) || (exp_s != got_s) || perr;
  endfunction

  // Slot following the last word of the message block.
  function automatic addr_t wb_slot(addr_t last_a);
    return last_a + addr_t'(1);
  endfunction
endpackage

// File: rtl/lbst_dec_path.sv
module lbst_dec_path
  import lbst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  offline,
  input  logic  tx_valid,
  input  logic  tx_sync,
  input  word_t tx_data,
  input  logic  rx_valid,
  input  logic  rx_sync,
  input  word_t rx_data,
  input  logic  rx_perr,
  output logic  dec_valid,
  output logic  dec_sync,
  output word_t dec_data,
  output logic  dec_perr
);
  logic  src_valid, src_sync, src_perr;
  word_t src_data;

  // Off-line: encoder output feeds the decoder directly, the bus is ignored.
  always_comb begin
    if (offline) begin
      src_valid = tx_valid;
      src_sync  = tx_sync;
      src_data  = tx_data;
      src_perr  = 1'b0;
    end else begin
      src_valid = rx_valid;
      src_sync  = rx_sync;
      src_data  = rx_data;
      src_perr  = rx_perr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_sync  <= 1'b0;
      dec_data  <= '0;
      dec_perr  <= 1'b0;
    end else begin
      dec_valid <= src_valid;
      if (src_valid) begin
        dec_sync <= src_sync;
        dec_data <= src_data;
        dec_perr <= src_perr;
      end
    end
  end
endmodule

// File: rtl/lbst_capture.sv
module lbst_capture
  import lbst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap_fire,
  input  logic  mode_ctl,
  input  logic  tx_sync,
  input  word_t tx_data,
  input  addr_t tx_addr,
  output logic  exp_sync,
  output word_t exp_data,
  output addr_t exp_addr,
  output logic  cap_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_sync <= 1'b0;
      exp_data <= '0;
      exp_addr <= '0;
      cap_mode <= 1'b0;
    end else if (cap_fire) begin
      exp_sync <= tx_sync;
      exp_data <= tx_data;
      exp_addr <= tx_addr;
      cap_mode <= mode_ctl;
    end
  end
endmodule

// File: rtl/lbst_ctrl.sv
module lbst_ctrl
  import lbst_pkg::*;
#(
  parameter int TMO_CYC = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  msg_start,
  input  logic  mode_ctl,
  input  logic  offline_req,
  input  logic  cap_fire,
  input  logic  dec_valid,
  input  logic  dec_sync,
  input  word_t dec_data,
  input  logic  dec_perr,
  input  logic  exp_sync,
  input  word_t exp_data,
  input  addr_t exp_addr,
  input  logic  cap_mode,
  output logic  offline_act,
  output logic  loop_fail,
  output logic  term_flag,
  output logic  wb_we,
  output addr_t wb_addr,
  output word_t wb_data,
  output logic  test_done,
  output logic  echo_eval,
  output logic  tmo_hit
);
  localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYC - 1);

  lbst_st_e      st;
  logic [CW-1:0] cnt;
  logic          bad;

  assign echo_eval = (st == ST_WAIT) && dec_valid && !msg_start;
  assign tmo_hit   = (st == ST_WAIT) && !dec_valid && (cnt == CNT_LAST) && !msg_start;
  assign bad       = echo_eval ? echo_bad(exp_data, exp_sync, dec_data, dec_sync, dec_perr)
                               : tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      offline_act <= 1'b0;
      loop_fail   <= 1'b0;
      term_flag   <= 1'b0;
      wb_we       <= 1'b0;
      wb_addr     <= '0;
      wb_data     <= '0;
      test_done   <= 1'b0;
    end else begin
      wb_we     <= 1'b0;
      test_done <= 1'b0;
      if (msg_start) begin
        st          <= ST_IDLE;
        cnt         <= '0;
        loop_fail   <= 1'b0;
        offline_act <= mode_ctl && offline_req;
      end else if (cap_fire) begin
        st  <= ST_WAIT;
        cnt <= '0;
      end else if (st == ST_WAIT) begin
        if (echo_eval || tmo_hit) begin
          st        <= ST_IDLE;
          test_done <= 1'b1;
          if (bad) loop_fail <= 1'b1;
          if (bad && !cap_mode) term_flag <= 1'b1;
          if (echo_eval && cap_mode) begin
            wb_we   <= 1'b1;
            wb_addr <= wb_slot(exp_addr);
            wb_data <= dec_data;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/loopback_selftest.sv
module loopback_selftest
  import lbst_pkg::*;
#(
  parameter int TMO_CYC = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ctl,
  input  logic          msg_start,
  input  logic          offline_req,
  input  logic          tx_valid,
  input  logic          tx_last,
  input  logic          tx_sync,
  input  logic [15:0]   tx_data,
  input  logic [12:0]   tx_addr,
  input  logic          rx_valid,
  input  logic          rx_sync,
  input  logic [15:0]   rx_data,
  input  logic          rx_perr,
  output logic          tx_en,
  output logic          loop_fail,
  output logic          term_flag,
  output logic          wb_we,
  output logic [12:0]   wb_addr,
  output logic [15:0]   wb_data,
  output logic          test_done
);
  logic  cap_fire;
  logic  offline_act;
  logic  dec_valid, dec_sync, dec_perr;
  word_t dec_data;
  logic  exp_sync, cap_mode;
  word_t exp_data;
  addr_t exp_addr;
  logic  echo_eval, tmo_hit;

  assign cap_fire = tx_valid && tx_last;
  assign tx_en    = !offline_act;

  lbst_dec_path u_dec (
    .clk(clk), .rst_n(rst_n), .offline(offline_act),
    .tx_valid(tx_valid), .tx_sync(tx_sync), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_sync(rx_sync), .rx_data(rx_data), .rx_perr(rx_perr),
    .dec_valid(dec_valid), .dec_sync(dec_sync), .dec_data(dec_data), .dec_perr(dec_perr)
  );

  lbst_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .mode_ctl(mode_ctl),
    .tx_sync(tx_sync), .tx_data(tx_data), .tx_addr(tx_addr),
    .exp_sync(exp_sync), .exp_data(exp_data), .exp_addr(exp_addr), .cap_mode(cap_mode)
  );

  lbst_ctrl #(.TMO_CYC(TMO_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .mode_ctl(mode_ctl),
    .offline_req(offline_req), .cap_fire(cap_fire),
    .dec_valid(dec_valid), .dec_sync(dec_sync), .dec_data(dec_data), .dec_perr(dec_perr),
    .exp_sync(exp_sync), .exp_data(exp_data), .exp_addr(exp_addr), .cap_mode(cap_mode),
    .offline_act(offline_act), .loop_fail(loop_fail), .term_flag(term_flag),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data), .test_done(test_done),
    .echo_eval(echo_eval), .tmo_hit(tmo_hit)
  );
endmodule

// File: rtl/lbst_chk.sv
module lbst_chk (
  input logic clk,
  input logic rst_n,
  input logic msg_start,
  input logic mode_ctl,
  input logic offline_req,
  input logic tx_en,
  input logic loop_fail,
  input logic term_flag,
  input logic wb_we,
  input logic test_done,
  input logic cap_mode,
  input logic tmo_hit
);
  a_r7_wb_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> $past(cap_mode));
  a_r7_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> test_done);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_start) |-> !loop_fail);
  a_r10_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_start && mode_ctl && offline_req) |-> !tx_en);
  a_r11_term_tx_on: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msg_start && !mode_ctl) |-> tx_en);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(term_flag) |-> term_flag);
  a_r8_flag_term_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_flag) |-> !$past(cap_mode));
  a_r6_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (loop_fail && !wb_we));
endmodule

bind loopback_selftest lbst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .mode_ctl(mode_ctl),
  .offline_req(offline_req), .tx_en(tx_en), .loop_fail(loop_fail),
  .term_flag(term_flag), .wb_we(wb_we), .test_done(test_done),
  .cap_mode(cap_mode), .tmo_hit(tmo_hit)
);

// File: tb/loopback_selftest_tb_top.sv
`timescale 1ns/1ps
module loopback_selftest_tb_top;
  localparam int TMO = 32;
  localparam int NV  = 12;

  typedef struct packed {
    logic        mode;
    logic        off;
    logic [7:0]  dly;
    logic [15:0] xr;
    logic        flip;
    logic        perr;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd3,  16'h0000, 1'b0, 1'b0},  // R2 pass
    '{1'b1, 1'b0, 8'd5,  16'h0100, 1'b0, 1'b0},  // R3 data
    '{1'b1, 1'b0, 8'd2,  16'h0000, 1'b1, 1'b0},  // R4 sync
    '{1'b1, 1'b0, 8'd4,  16'h0000, 1'b0, 1'b1},  // R5 parity
    '{1'b1, 1'b0, 8'd31, 16'h0000, 1'b0, 1'b0},  // R6 last accepted
    '{1'b1, 1'b0, 8'd32, 16'h0000, 1'b0, 1'b0},  // R6 timeout
    '{1'b1, 1'b1, 8'd1,  16'hFFFF, 1'b1, 1'b1},  // R10 off-line, bus junk
    '{1'b1, 1'b0, 8'd1,  16'h0000, 1'b0, 1'b0},  // R10 back on-line
    '{1'b0, 1'b0, 8'd6,  16'h0000, 1'b0, 1'b0},  // R2 terminal pass
    '{1'b0, 1'b1, 8'd3,  16'h0000, 1'b0, 1'b0},  // R11 request ignored
    '{1'b0, 1'b0, 8'd7,  16'h8000, 1'b0, 1'b0},  // R8 terminal fail
    '{1'b0, 1'b0, 8'd2,  16'h0000, 1'b0, 1'b0}   // R8 flag sticky
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ctl = 1'b0, msg_start = 1'b0, offline_req = 1'b0;
  logic tx_valid = 1'b0, tx_last = 1'b0, tx_sync = 1'b0;
  logic [15:0] tx_data = '0;
  logic [12:0] tx_addr = '0;
  logic rx_valid = 1'b0, rx_sync = 1'b0, rx_perr = 1'b0;
  logic [15:0] rx_data = '0;
  logic tx_en, loop_fail, term_flag, wb_we, test_done;
  logic [12:0] wb_addr;
  logic [15:0] wb_data;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  loopback_selftest #(.TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ctl(mode_ctl), .msg_start(msg_start),
    .offline_req(offline_req), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_sync(tx_sync), .tx_data(tx_data), .tx_addr(tx_addr),
    .rx_valid(rx_valid), .rx_sync(rx_sync), .rx_data(rx_data), .rx_perr(rx_perr),
    .tx_en(tx_en), .loop_fail(loop_fail), .term_flag(term_flag),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data), .test_done(test_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic exp_flag;
    exp_flag = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 loop_fail", {31'd0, loop_fail}, 32'd0);
    check("R1 term_flag", {31'd0, term_flag}, 32'd0);
    check("R1 wb_we", {31'd0, wb_we}, 32'd0);
    check("R1 test_done", {31'd0, test_done}, 32'd0);
    check("R1 tx_en", {31'd0, tx_en}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic off_eff, echoed, fail;
      logic [15:0] wa, wb;
      logic [12:0] adr;
      int nwr, ndone;
      logic [12:0] got_a;
      logic [15:0] got_d;
      v = VECS[i];
      off_eff = v.off & v.mode;
      echoed  = off_eff || (int'(v.dly) <= TMO - 1);
      fail    = off_eff ? 1'b0 : (!echoed || (v.xr != 16'h0) || v.flip || v.perr);
      if (fail && !v.mode) exp_flag = 1'b1;
      wa  = 16'h1000 + 16'(i);
      wb  = 16'h5A00 + 16'(i) * 16'h0111;
      adr = 13'h0100 + 13'(i) * 13'd8;

      msg_start = 1'b1; mode_ctl = v.mode; offline_req = v.off;
      @(negedge clk);
      msg_start = 1'b0;
      check("R9 cleared by start", {31'd0, loop_fail}, 32'd0);
      check("R10/R11 tx_en", {31'd0, tx_en}, {31'd0, !off_eff});
      // first word; a wrong echo of it on the bus must not count (R12)
      tx_valid = 1'b1; tx_last = 1'b0; tx_sync = 1'b1; tx_data = wa; tx_addr = adr - 13'd1;
      rx_valid = 1'b1; rx_sync = 1'b0; rx_data = ~wa; rx_perr = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_perr = 1'b0;
      tx_last = 1'b1; tx_sync = 1'(i); tx_data = wb; tx_addr = adr;
      nwr = 0; ndone = 0; got_a = '0; got_d = '0;
      for (int c = 1; c <= TMO + 4; c++) begin
        @(negedge clk);
        if (c == 1) begin tx_valid = 1'b0; tx_last = 1'b0; end
        if (wb_we) begin nwr++; got_a = wb_addr; got_d = wb_data; end
        if (test_done) ndone++;
        if (c == int'(v.dly)) begin
          rx_valid = 1'b1; rx_data = wb ^ v.xr; rx_sync = 1'(i) ^ v.flip; rx_perr = v.perr;
        end else begin
          rx_valid = 1'b0; rx_perr = 1'b0;
        end
      end
      rx_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R2-R6 loop_fail vec%0d", i), {31'd0, loop_fail}, {31'd0, fail});
      check($sformatf("R2 one done vec%0d", i), 32'(ndone), 32'd1);
      check($sformatf("R7 write count vec%0d", i), 32'(nwr), (v.mode && echoed) ? 32'd1 : 32'd0);
      if (v.mode && echoed) begin
        check($sformatf("R7 wb_addr vec%0d", i), {19'd0, got_a}, {19'd0, adr + 13'd1});
        check($sformatf("R7 wb_data vec%0d", i), {16'd0, got_d},
              {16'd0, off_eff ? wb : (wb ^ v.xr)});
      end
      check($sformatf("R8 term_flag vec%0d", i), {31'd0, term_flag}, {31'd0, exp_flag});
      check($sformatf("R10 tx_en held vec%0d", i), {31'd0, tx_en}, {31'd0, !off_eff});
    end

    // R10 off-line state, then reset returns everything to idle (R1)
    msg_start = 1'b1; mode_ctl = 1'b1; offline_req = 1'b1;
    @(negedge clk);
    msg_start = 1'b0; offline_req = 1'b0;
    check("R10 tx_en low", {31'd0, tx_en}, 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 tx_en after reset", {31'd0, tx_en}, 32'd1);
    check("R1 term_flag after reset", {31'd0, term_flag}, 32'd0);
    check("R1 loop_fail after reset", {31'd0, loop_fail}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule